// File: doc/BRIEF.md
# Shared light pen sense controller

This block lets several display units connected in a chain share one light pen. Each unit holds a sticky sense flag that is set by a rising edge on the pen's sense pulse. A standalone unit or the master puts its flag onto a shared wired-OR sense line. Any unit can clear the master's flag through a shared wired-OR reset line. A slave ignores its own flag and reads the shared line instead. The pen is therefore wired to the master, and every unit can still find out whether the pen sees one of its own LEDs.

When the pen switch is pressed on the master, the block takes the display away from normal refresh and lights one column at a time. Before each column it pulses the reset line. It then waits a settle time and samples the sense value. The first column that responds is reported as a hit. If the master finds no hit on its own columns, it grants the scan to each slave in turn. After each slave reports that it is done, the master checks its flag to learn whether the pen saw that slave's display. A slave starts its own scan when it receives a grant from the master.

Top module: `lpen_share_ctrl`

## Requirements
- R1: A rising edge on sense_pulse_i that is first sampled high at clock edge n sets the sticky flag at edge n+2, after two synchronizer stages and an edge detector. On a master or standalone unit (slave_ni=1) the flag is shown on sh_sense_oe_o. It stays set through later pulses and idle time until it is cleared.
- R2: When sh_reset_i is high at a clock edge, the flag is cleared at that edge. If a set and a clear arrive at the same edge, the clear wins.
- R3: With slave_ni=1 the scan samples the unit's own flag. With slave_ni=0 the scan samples sh_sense_i, pulses on sense_pulse_i have no effect on the result, and sh_sense_oe_o stays 0.
- R4: On a master or standalone unit, a falling edge on pen_sw_ni starts a scan. A slave ignores pen_sw_ni and starts a scan on a rising edge of scan_grant_i.
- R5: col_en_o is at most one-hot, and bit i drives column i. Columns are lit in ascending order from column 0. Each column stays lit for exactly SETTLE_CYCLES+2 cycles.
- R6: sh_reset_oe_o is high in the first cycle of each lit column and low in the other cycles of that column.
- R7: When a column's sample sees the sense value high, res_valid_o pulses for one cycle with res_hit_o=1, res_remote_o=0 and res_col_o equal to that column's index. No further column is lit after that.
- R8: A slave that gets no hit pulses res_valid_o after its last column, with res_hit_o=0.
- R9: A master with no hit of its own raises slave_grant_o one bit at a time, in order from bit 0. Each bit is held until the matching slave_done_i bit is seen. col_en_o stays 0 during this phase.
- R10: If the flag is set when slave_done_i[k] is seen, the master pulses res_valid_o with res_remote_o=1 and res_hit_o=0 and issues no further grants. If the flag is still clear after the last slave, res_valid_o pulses with both res_hit_o and res_remote_o at 0.
- R11: scan_active_o is high from the first lit column through the grant phase. It is low in the cycle res_valid_o pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sense_pulse_i | input | 1 | Pen photodetector pulse (asynchronous) |
| pen_sw_ni | input | 1 | Pen switch, active low |
| slave_ni | input | 1 | Slave select, active low |
| scan_grant_i | input | 1 | Scan grant from the master (used when slave) |
| sh_sense_i | input | 1 | Resolved level of the shared sense line |
| sh_sense_oe_o | output | 1 | Pull enable for the shared sense line |
| sh_reset_i | input | 1 | Resolved level of the shared reset line |
| sh_reset_oe_o | output | 1 | Pull enable for the shared reset line |
| slave_grant_o | output | NUM_SLAVES | One-hot scan grant to the slaves |
| slave_done_i | input | NUM_SLAVES | Scan-finished strobe from each slave |
| col_en_o | output | NUM_COLS | Column drive, one-hot |
| scan_active_o | output | 1 | Scan owns the display; refresh is paused |
| res_valid_o | output | 1 | Result strobe |
| res_hit_o | output | 1 | Pen seen on one of this unit's columns |
| res_remote_o | output | 1 | Pen seen on a slave's display |
| res_col_o | output | $clog2(NUM_COLS) | Index of the column that was hit |

## Verification
The master is scanned with the pen placed on its first column, on its last column, on a random column, on a chosen slave, and nowhere. These cases separate an early stop from a full sweep, a local hit from a remote hit, and a remote hit from no hit at all. They also show that grants stop at the right slave. The slave is scanned with a pen on the shared line, with a pen only on its own local input, and with both. This shows which of the two sources the slave actually samples. Directed idle tests check the sync latency, that the flag is sticky, that a clear beats a simultaneous set, and that a slave ignores the pen switch.

// File: rtl/lpen_pkg.sv
package lpen_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_SETTLE,
    ST_SAMPLE,
    ST_GRANT
  } scan_st_e;
endpackage

// File: rtl/lpen_edge_sync.sv
module lpen_edge_sync #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  // [0],[1] synchronize, [2] holds previous synced value
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= {3{RST_VAL}};
    else         sh_q <= {sh_q[1:0], d_i};
  end

  assign rise_o = sh_q[1] & ~sh_q[2];
  assign fall_o = ~sh_q[1] & sh_q[2];
endmodule

// File: rtl/lpen_sense_latch.sv
module lpen_sense_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (clr_i) flag_o <= 1'b0;  // clear beats set
    else if (set_i) flag_o <= 1'b1;
  end
endmodule

// File: rtl/lpen_scan_seq.sv
module lpen_scan_seq
  import lpen_pkg::*;
#(
  parameter int NUM_COLS      = 8,
  parameter int SETTLE_CYCLES = 4,
  parameter int NUM_SLAVES    = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        is_master_i,
  input  logic                        pen_fall_i,
  input  logic                        grant_rise_i,
  input  logic                        sensed_i,
  input  logic [NUM_SLAVES-1:0]       slave_done_i,
  output logic [NUM_COLS-1:0]         col_en_o,
  output logic                        clr_o,
  output logic                        active_o,
  output logic [NUM_SLAVES-1:0]       slave_grant_o,
  output logic                        res_valid_o,
  output logic                        res_hit_o,
  output logic                        res_remote_o,
  output logic [$clog2(NUM_COLS)-1:0] res_col_o
);
  localparam int COL_W = $clog2(NUM_COLS);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam int SLV_W = (NUM_SLAVES > 1) ? $clog2(NUM_SLAVES) : 1;
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);
  localparam logic [SLV_W-1:0] LAST_SLV = SLV_W'(NUM_SLAVES - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SETTLE_CYCLES - 1);

  scan_st_e         st_q;
  logic [COL_W-1:0] col_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SLV_W-1:0] slv_q;
  logic             lit;

  assign lit      = (st_q == ST_CLEAR) || (st_q == ST_SETTLE) || (st_q == ST_SAMPLE);
  assign clr_o    = (st_q == ST_CLEAR);
  assign active_o = (st_q != ST_IDLE);

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    assign col_en_o[c] = lit && (col_q == COL_W'(c));
  end

  for (genvar s = 0; s < NUM_SLAVES; s++) begin : g_gnt
    assign slave_grant_o[s] = (st_q == ST_GRANT) && (slv_q == SLV_W'(s));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      col_q        <= '0;
      cnt_q        <= '0;
      slv_q        <= '0;
      res_valid_o  <= 1'b0;
      res_hit_o    <= 1'b0;
      res_remote_o <= 1'b0;
      res_col_o    <= '0;
    end else begin
      res_valid_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if ((is_master_i && pen_fall_i) || (!is_master_i && grant_rise_i)) begin
            st_q  <= ST_CLEAR;
            col_q <= '0;
          end
        end
        ST_CLEAR: begin
          cnt_q <= '0;
          st_q  <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (cnt_q == LAST_CNT) st_q <= ST_SAMPLE;
          else                   cnt_q <= cnt_q + 1'b1;
        end
        ST_SAMPLE: begin
          if (sensed_i) begin
            st_q         <= ST_IDLE;
            res_valid_o  <= 1'b1;
            res_hit_o    <= 1'b1;
            res_remote_o <= 1'b0;
            res_col_o    <= col_q;
          end else if (col_q != LAST_COL) begin
            col_q <= col_q + 1'b1;
            st_q  <= ST_CLEAR;
          end else if (is_master_i) begin
            slv_q <= '0;
            st_q  <= ST_GRANT;
          end else begin
            st_q         <= ST_IDLE;
            res_valid_o  <= 1'b1;
            res_hit_o    <= 1'b0;
            res_remote_o <= 1'b0;
            res_col_o    <= '0;
          end
        end
        ST_GRANT: begin
          if (slave_done_i[slv_q]) begin
            if (sensed_i || slv_q == LAST_SLV) begin
              st_q         <= ST_IDLE;
              res_valid_o  <= 1'b1;
              res_hit_o    <= 1'b0;
              res_remote_o <= sensed_i;
              res_col_o    <= '0;
            end else begin
              slv_q <= slv_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lpen_share_ctrl.sv
module lpen_share_ctrl #(
  parameter int NUM_COLS      = 8,
  parameter int SETTLE_CYCLES = 4,
  parameter int NUM_SLAVES    = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        sense_pulse_i,
  input  logic                        pen_sw_ni,
  input  logic                        slave_ni,
  input  logic                        scan_grant_i,
  input  logic                        sh_sense_i,
  output logic                        sh_sense_oe_o,
  input  logic                        sh_reset_i,
  output logic                        sh_reset_oe_o,
  output logic [NUM_SLAVES-1:0]       slave_grant_o,
  input  logic [NUM_SLAVES-1:0]       slave_done_i,
  output logic [NUM_COLS-1:0]         col_en_o,
  output logic                        scan_active_o,
  output logic                        res_valid_o,
  output logic                        res_hit_o,
  output logic                        res_remote_o,
  output logic [$clog2(NUM_COLS)-1:0] res_col_o
);
  logic sense_rise, sense_fall_unused;
  logic sw_rise_unused, sw_fall;
  logic grant_rise, grant_fall_unused;
  logic flag, own_clr, is_master, sensed;

  assign is_master = slave_ni;

  lpen_edge_sync #(.RST_VAL(1'b0)) i_sense_sync (
    .clk_i, .rst_ni, .d_i(sense_pulse_i), .rise_o(sense_rise), .fall_o(sense_fall_unused)
  );

  lpen_edge_sync #(.RST_VAL(1'b1)) i_sw_sync (
    .clk_i, .rst_ni, .d_i(pen_sw_ni), .rise_o(sw_rise_unused), .fall_o(sw_fall)
  );

  lpen_edge_sync #(.RST_VAL(1'b0)) i_grant_sync (
    .clk_i, .rst_ni, .d_i(scan_grant_i), .rise_o(grant_rise), .fall_o(grant_fall_unused)
  );

  // shared reset line is the resolved wired-OR, own pull included
  lpen_sense_latch i_latch (
    .clk_i, .rst_ni, .set_i(sense_rise), .clr_i(sh_reset_i | own_clr), .flag_o(flag)
  );

  assign sensed        = is_master ? flag : sh_sense_i;
  assign sh_sense_oe_o = is_master & flag;
  assign sh_reset_oe_o = own_clr;

  lpen_scan_seq #(
    .NUM_COLS(NUM_COLS), .SETTLE_CYCLES(SETTLE_CYCLES), .NUM_SLAVES(NUM_SLAVES)
  ) i_seq (
    .clk_i, .rst_ni,
    .is_master_i  (is_master),
    .pen_fall_i   (sw_fall),
    .grant_rise_i (grant_rise),
    .sensed_i     (sensed),
    .slave_done_i (slave_done_i),
    .col_en_o     (col_en_o),
    .clr_o        (own_clr),
    .active_o     (scan_active_o),
    .slave_grant_o(slave_grant_o),
    .res_valid_o  (res_valid_o),
    .res_hit_o    (res_hit_o),
    .res_remote_o (res_remote_o),
    .res_col_o    (res_col_o)
  );
endmodule

// File: rtl/lpen_share_ctrl_chk.sv
module lpen_share_ctrl_chk #(
  parameter int NUM_COLS   = 8,
  parameter int NUM_SLAVES = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  slave_ni,
  input logic                  sh_sense_oe_o,
  input logic                  sh_reset_i,
  input logic                  sh_reset_oe_o,
  input logic [NUM_SLAVES-1:0] slave_grant_o,
  input logic [NUM_COLS-1:0]   col_en_o,
  input logic                  scan_active_o,
  input logic                  res_valid_o
);
  a_r5_col_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(col_en_o));

  a_r11_cols_in_scan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|col_en_o) |-> scan_active_o);

  a_r3_slave_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slave_ni |-> !sh_sense_oe_o);

  a_r2_shared_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_reset_i |=> !sh_sense_oe_o);

  a_r6_clear_on_new_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|col_en_o) && col_en_o != $past(col_en_o)) |-> sh_reset_oe_o);

  a_r7_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);

  a_r9_grant_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(slave_grant_o));

  a_r9_grant_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|slave_grant_o) |-> (col_en_o == '0 && scan_active_o && slave_ni));

  a_r11_idle_at_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !scan_active_o);
endmodule

bind lpen_share_ctrl lpen_share_ctrl_chk #(
  .NUM_COLS(NUM_COLS), .NUM_SLAVES(NUM_SLAVES)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .slave_ni     (slave_ni),
  .sh_sense_oe_o(sh_sense_oe_o),
  .sh_reset_i   (sh_reset_i),
  .sh_reset_oe_o(sh_reset_oe_o),
  .slave_grant_o(slave_grant_o),
  .col_en_o     (col_en_o),
  .scan_active_o(scan_active_o),
  .res_valid_o  (res_valid_o)
);

// File: tb/test_lpen_share_ctrl.sv
`timescale 1ns/1ps
module test_lpen_share_ctrl;
  localparam int NC = 8;
  localparam int SC = 4;
  localparam int NS = 2;
  localparam int CW = $clog2(NC);

  logic clk = 1'b0, rst_n = 1'b0;
  logic pen_sw_n = 1'b1, slave_n = 1'b1, scan_grant = 1'b0;
  logic [NS-1:0] slave_done = '0;
  logic man_pulse = 1'b0, man_rst = 1'b0, man_sh = 1'b0;
  logic pen_q = 1'b0, mflag = 1'b0;
  int pen_col = -1, sh_pen_col = -1;

  logic sense_pulse, sh_sense, sh_reset;
  logic sh_sense_oe, sh_reset_oe, scan_active, res_valid, res_hit, res_remote;
  logic [NS-1:0] slave_grant;
  logic [NC-1:0] col_en;
  logic [CW-1:0] res_col;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  assign sense_pulse = pen_q | man_pulse;
  assign sh_sense    = mflag | man_sh;
  assign sh_reset    = sh_reset_oe | man_rst;

  lpen_share_ctrl #(.NUM_COLS(NC), .SETTLE_CYCLES(SC), .NUM_SLAVES(NS)) i_lpen_share_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sense_pulse_i(sense_pulse), .pen_sw_ni(pen_sw_n),
    .slave_ni(slave_n), .scan_grant_i(scan_grant), .sh_sense_i(sh_sense),
    .sh_sense_oe_o(sh_sense_oe), .sh_reset_i(sh_reset), .sh_reset_oe_o(sh_reset_oe),
    .slave_grant_o(slave_grant), .slave_done_i(slave_done), .col_en_o(col_en),
    .scan_active_o(scan_active), .res_valid_o(res_valid), .res_hit_o(res_hit),
    .res_remote_o(res_remote), .res_col_o(res_col)
  );

  function automatic bit lit_at(int c);
    return (c >= 0) && (c < NC) && col_en[c];
  endfunction

  function automatic int onehot_idx(logic [NC-1:0] v);
    for (int i = 0; i < NC; i++) if (v[i]) return i;
    return -1;
  endfunction

  // pen on the local input, and a model of a remote master flag on the shared line
  always @(negedge clk) begin
    pen_q <= lit_at(pen_col);
    if (!rst_n || sh_reset_oe) mflag <= 1'b0;
    else if (lit_at(sh_pen_col)) mflag <= 1'b1;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  // column tracking state
  logic [NC-1:0] prev_en;
  int next_idx, run_len, bad_order, bad_len, bad_clr, prev_active;

  task automatic track_reset();
    prev_en = '0; next_idx = 0; run_len = 0;
    bad_order = 0; bad_len = 0; bad_clr = 0; prev_active = 0;
  endtask

  task automatic track_cols();
    if (col_en != prev_en) begin
      if (prev_en != '0 && run_len != SC + 2) bad_len++;
      if (col_en != '0) begin
        if (onehot_idx(col_en) != next_idx) bad_order++;
        next_idx++;
        if (!sh_reset_oe) bad_clr++;
        run_len = 1;
      end
    end else if (col_en != '0) begin
      run_len++;
      if (sh_reset_oe) bad_clr++;
    end
    prev_en = col_en;
  endtask

  task automatic check_cols(input int exp_cols);
    chk("R5", "column order errors", bad_order, 0);
    chk("R5", "column length errors", bad_len, 0);
    chk("R5", "columns lit", next_idx, exp_cols);
    chk("R6", "reset pulse errors", bad_clr, 0);
  endtask

  // master scan: own_col = pen on this display, slv = pen on that slave's display
  task automatic run_master(input int own_col, input int slv);
    int g_cur, g_wait, g_seen, g_bad, k;
    bit got;
    slave_n = 1'b1; pen_col = own_col; sh_pen_col = -1;
    track_reset();
    g_cur = -1; g_wait = 0; g_seen = 0; g_bad = 0; got = 0;
    pen_sw_n = 1'b0;
    for (k = 0; k < 3000 && !got; k++) begin
      @(negedge clk);
      if (k == 2) pen_sw_n = 1'b1;
      track_cols();
      man_rst = 1'b0; man_pulse = 1'b0; slave_done = '0;
      if (slave_grant != '0) begin
        int gi = -1;
        for (int i = 0; i < NS; i++) if (slave_grant[i]) gi = i;
        if (gi != g_cur) begin
          if (gi != g_seen) g_bad++;
          g_seen++; g_cur = gi; g_wait = 0;
        end
        g_wait++;
        if (g_wait == 2 && gi == slv) man_rst = 1'b1;
        if (g_wait == 3 && gi == slv) man_pulse = 1'b1;
        if (g_wait == 8) slave_done[gi] = 1'b1;
      end
      if (res_valid) begin
        got = 1;
        chk("R11", "scan_active at result", int'(scan_active), 0);
        chk("R11", "scan_active before result", prev_active, 1);
      end
      prev_active = int'(scan_active);
    end
    man_rst = 1'b0; man_pulse = 1'b0; slave_done = '0; pen_col = -1;
    chk("R7", "result seen", int'(got), 1);
    if (own_col >= 0) begin
      chk("R7", "hit", int'(res_hit), 1);
      chk("R7", "column", int'(res_col), own_col);
      chk("R7", "remote", int'(res_remote), 0);
      chk("R9", "grants", g_seen, 0);
      check_cols(own_col + 1);
    end else begin
      chk("R10", "hit", int'(res_hit), 0);
      chk("R10", "remote", int'(res_remote), int'(slv >= 0));
      chk("R9", "grants", g_seen, (slv >= 0) ? slv + 1 : NS);
      chk("R9", "grant order errors", g_bad, 0);
      check_cols(NC);
    end
    @(negedge clk);
    chk("R7", "valid one cycle", int'(res_valid), 0);
    chk("R9", "grants after result", int'(slave_grant), 0);
    repeat (4) @(negedge clk);
  endtask

  // slave scan: sh_col = pen on the master's flag, loc_col = pen on local input
  task automatic run_slave(input int sh_col, input int loc_col);
    int k;
    bit got;
    slave_n = 1'b0; sh_pen_col = sh_col; pen_col = loc_col;
    track_reset(); got = 0;
    scan_grant = 1'b1;
    for (k = 0; k < 3000 && !got; k++) begin
      @(negedge clk);
      track_cols();
      chk("R3", "slave sense drive", int'(sh_sense_oe), 0);
      if (res_valid) got = 1;
    end
    scan_grant = 1'b0; sh_pen_col = -1; pen_col = -1;
    chk("R4", "slave result seen", int'(got), 1);
    if (sh_col >= 0) begin
      chk("R3", "slave hit", int'(res_hit), 1);
      chk("R3", "slave column", int'(res_col), sh_col);
      check_cols(sh_col + 1);
    end else begin
      chk("R8", "slave no-hit", int'(res_hit), 0);
      chk("R8", "slave remote", int'(res_remote), 0);
      check_cols(NC);
    end
    repeat (4) @(negedge clk);
    slave_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int unsigned s;
    s = $urandom(32'd707);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "reset scan_active", int'(scan_active), 0);
    chk("R5", "reset col_en", int'(col_en), 0);
    chk("R1", "reset sense drive", int'(sh_sense_oe), 0);
    chk("R7", "reset res_valid", int'(res_valid), 0);
    chk("R9", "reset grants", int'(slave_grant), 0);
    chk("R6", "reset reset drive", int'(sh_reset_oe), 0);

    // R1 latency and stickiness
    man_pulse = 1'b1; @(negedge clk); man_pulse = 1'b0;
    @(negedge clk);
    chk("R1", "flag one edge after sample", int'(sh_sense_oe), 0);
    @(negedge clk);
    chk("R1", "flag two edges after sample", int'(sh_sense_oe), 1);
    repeat (20) @(negedge clk);
    chk("R1", "flag sticky", int'(sh_sense_oe), 1);
    man_pulse = 1'b1; @(negedge clk); man_pulse = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1", "flag after second pulse", int'(sh_sense_oe), 1);

    // R2 shared clear, then clear beats a simultaneous set
    man_rst = 1'b1; @(negedge clk); man_rst = 1'b0;
    chk("R2", "cleared by shared reset", int'(sh_sense_oe), 0);
    repeat (3) @(negedge clk);
    man_pulse = 1'b1; @(negedge clk); man_pulse = 1'b0;
    @(negedge clk);
    man_rst = 1'b1; @(negedge clk); man_rst = 1'b0;
    chk("R2", "clear wins over set", int'(sh_sense_oe), 0);
    repeat (3) @(negedge clk);
    chk("R2", "stays clear", int'(sh_sense_oe), 0);

    // R3 slave never drives shared sense; R4 slave ignores switch
    slave_n = 1'b0;
    man_pulse = 1'b1; @(negedge clk); man_pulse = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3", "slave no drive after pulse", int'(sh_sense_oe), 0);
    pen_sw_n = 1'b0; repeat (3) @(negedge clk); pen_sw_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R4", "slave ignores switch", int'(scan_active), 0);
    slave_n = 1'b1;
    man_rst = 1'b1; @(negedge clk); man_rst = 1'b0;
    repeat (2) @(negedge clk);

    // directed master corners
    run_master(0, -1);
    run_master(NC - 1, -1);
    run_master(-1, -1);
    run_master(-1, 0);
    run_master(-1, NS - 1);
    // directed slave corners
    run_slave(0, -1);
    run_slave(-1, 3);
    run_slave(NC - 1, 2);
    run_slave(-1, -1);

    for (int t = 0; t < 14; t++) begin
      case ($urandom_range(0, 2))
        0: run_master($urandom_range(0, NC - 1), -1);
        1: run_master(-1, $urandom_range(0, NS - 1));
        default: run_master(-1, -1);
      endcase
    end
    for (int t = 0; t < 10; t++) begin
      int a, b;
      a = ($urandom_range(0, 3) == 0) ? -1 : $urandom_range(0, NC - 1);
      b = ($urandom_range(0, 1) == 0) ? -1 : $urandom_range(0, NC - 1);
      run_slave(a, b);
    end

    summary();
    $finish;
  end
endmodule